// File: doc/BRIEF.md
# Salsa20 Keystream Engine

This block is a stream cipher engine of the Salsa20 family. Software, or a sequencer, first sets it up. It selects the round count (20, 12 or 8) and the key length. It writes the key as four 64-bit chunks and then writes a 64-bit nonce. A one-cycle init pulse then starts the first 512-bit keystream block, which begins at block counter zero. After a fixed latency the engine raises `ready_o`.

While ready is high, each request presents a 64-bit data word with `valid_i`. The engine XORs that word with the next unused 64 bits of keystream and returns the result one cycle later. A new request may be made every cycle. Encryption and decryption are the same operation.

The current block sits in an eight-word buffer. A second block register is filled in the background by a core that performs one double round per clock. When a burst drains the buffer faster than the core can refill it, ready drops until the next block arrives.

Top module: `salsa_stream`

## Requirements
- R1: While `rst_ni` is low, `ready_o` and `dvalid_o` are 0 and `data_o` is all zeros.
- R2: `rounds_i` is sampled on the init cycle. Code 1 selects 12 rounds, code 2 selects 8 rounds, and codes 0 and 3 select 20 rounds.
- R3: A key write with `key_we_i` stores `key_chunk_i` as key bytes 8c..8c+7, where c is `key_sel_i`. Byte 8c sits in bits 7:0, and key words are read little-endian. `key_len_i` is sampled at init. A value of 1 selects a 32-byte key with the "expand 32-byte k" constants. A value of 0 selects a 16-byte key made of chunks 0 and 1, used twice, with the "expand 16-byte k" constants.
- R4: The nonce fills state words 6 and 7, with bits 31:0 going to word 6. The 64-bit block counter fills words 8 and 9. It is 0 for the first block after init and increases by one for each later block.
- R5: If init is sampled on clock edge k, `ready_o` first becomes 1 after edge k+n+2, where n is half the round count.
- R6: An accepted request returns `data_i` XOR the next keystream word on `data_o`, with `dvalid_o` high, after the following edge. Word j of a block is state words 2j (low half) and 2j+1 (high half) after the final addition.
- R7: When a request is made on every cycle, successive requests are accepted on consecutive cycles. Between blocks, ready stays low for max(0, n-6) cycles.
- R8: A request made while `ready_o` is low is ignored. `dvalid_o` stays low and no keystream word is used.
- R9: `data_o` holds its value on every cycle in which no request is accepted.
- R10: Init takes priority over everything else. `ready_o` and `dvalid_o` are 0 after the init edge, a request made in the same cycle as init is ignored, and keystream starts again at counter 0.
- R11: Requests spaced out with idle cycles between them use consecutive keystream words, with no word skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rounds_i | input | 2 | Round count select, sampled at init |
| key_len_i | input | 1 | 1 = 32-byte key, 0 = 16-byte key, sampled at init |
| key_we_i | input | 1 | Key chunk write strobe |
| key_sel_i | input | 2 | Key chunk index |
| key_chunk_i | input | 64 | Key chunk data |
| nonce_we_i | input | 1 | Nonce write strobe |
| nonce_i | input | 64 | Nonce data |
| init_i | input | 1 | Start keystream from counter 0 |
| valid_i | input | 1 | Request strobe |
| data_i | input | 64 | Word to encrypt or decrypt |
| ready_o | output | 1 | A keystream word is available |
| dvalid_o | output | 1 | `data_o` carries a new result |
| data_o | output | 64 | XOR result |

## Verification
The bound checker checks several properties on every cycle:
- A result strobe appears only after an accepted request, and never while the engine is busy.
- The output word holds between accepted requests.
- Init clears ready and the result strobe.
- Ready falls only after an init or a request.

The keystream values, the init-to-ready latency, the refill stall between blocks, the counter order and both constant sets are shown only by the bench. For each round code and key length it compares every returned word against a Salsa20 model computed in the bench.

// File: rtl/salsa_pkg.sv
package salsa_pkg;
  localparam int WORD_W    = 32;
  localparam int N_WORDS   = 16;
  localparam int BLK_W     = WORD_W * N_WORDS;
  localparam int DATA_W    = 64;
  localparam int OUT_WORDS = BLK_W / DATA_W;
  localparam int IDX_W     = $clog2(OUT_WORDS);
  localparam int KEY_W     = 256;
  localparam int CHUNK_W   = 64;
  localparam int N_CHUNKS  = KEY_W / CHUNK_W;
  localparam int SEL_W     = $clog2(N_CHUNKS);
  localparam int NONCE_W   = 64;
  localparam int CNT_W     = 64;
  localparam int RND_W     = 4;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  localparam logic [WORD_W-1:0] K_C0    = 32'h61707865;
  localparam logic [WORD_W-1:0] K_C1_32 = 32'h3320646e;
  localparam logic [WORD_W-1:0] K_C1_16 = 32'h3120646e;
  localparam logic [WORD_W-1:0] K_C2_32 = 32'h79622d32;
  localparam logic [WORD_W-1:0] K_C2_16 = 32'h79622d36;
  localparam logic [WORD_W-1:0] K_C3    = 32'h6b206574;

  // double rounds per block
  function automatic logic [RND_W-1:0] dbl_rounds(logic [1:0] sel);
    case (sel)
      2'd1:    return RND_W'(6);
      2'd2:    return RND_W'(4);
      default: return RND_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/salsa_qr.sv
module salsa_qr import salsa_pkg::*; (
  input  logic [WORD_W-1:0] y0_i,
  input  logic [WORD_W-1:0] y1_i,
  input  logic [WORD_W-1:0] y2_i,
  input  logic [WORD_W-1:0] y3_i,
  output logic [WORD_W-1:0] z0_o,
  output logic [WORD_W-1:0] z1_o,
  output logic [WORD_W-1:0] z2_o,
  output logic [WORD_W-1:0] z3_o
);
  function automatic logic [WORD_W-1:0] rotl(logic [WORD_W-1:0] v, int s);
    return (v << s) | (v >> (WORD_W - s));
  endfunction

  always_comb begin
    z1_o = y1_i ^ rotl(y0_i + y3_i, 7);
    z2_o = y2_i ^ rotl(z1_o + y0_i, 9);
    z3_o = y3_i ^ rotl(z2_o + z1_o, 13);
    z0_o = y0_i ^ rotl(z3_o + z2_o, 18);
  end
endmodule

// File: rtl/salsa_dround.sv
module salsa_dround import salsa_pkg::*; (
  input  state_t s_i,
  output state_t s_o
);
  logic [WORD_W-1:0] mid [N_WORDS];
  logic [WORD_W-1:0] fin [N_WORDS];

  // column pass: quad i starts at the diagonal word 5i, stride 4
  for (genvar i = 0; i < 4; i++) begin : g_col
    localparam int A = (5*i)      % 16;
    localparam int B = (5*i + 4)  % 16;
    localparam int C = (5*i + 8)  % 16;
    localparam int D = (5*i + 12) % 16;
    salsa_qr u_qr (
      .y0_i(s_i[A]), .y1_i(s_i[B]), .y2_i(s_i[C]), .y3_i(s_i[D]),
      .z0_o(mid[A]), .z1_o(mid[B]), .z2_o(mid[C]), .z3_o(mid[D])
    );
  end

  // row pass: quad i starts at the diagonal word, wraps inside row i
  for (genvar i = 0; i < 4; i++) begin : g_row
    localparam int A = 4*i + (i % 4);
    localparam int B = 4*i + ((i + 1) % 4);
    localparam int C = 4*i + ((i + 2) % 4);
    localparam int D = 4*i + ((i + 3) % 4);
    salsa_qr u_qr (
      .y0_i(mid[A]), .y1_i(mid[B]), .y2_i(mid[C]), .y3_i(mid[D]),
      .z0_o(fin[A]), .z1_o(fin[B]), .z2_o(fin[C]), .z3_o(fin[D])
    );
  end

  for (genvar j = 0; j < N_WORDS; j++) begin : g_out
    assign s_o[j] = fin[j];
  end
endmodule

// File: rtl/salsa_core.sv
module salsa_core import salsa_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               take_i,
  input  logic               klen_i,
  input  logic [1:0]         rsel_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [NONCE_W-1:0] nonce_i,
  output logic               full_o,
  output state_t             blk_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FF, S_FULL} core_st_e;

  core_st_e          st_q;
  state_t            x_q, orig_q, blk_q, dr;
  logic [CNT_W-1:0]  ctr_q;
  logic [RND_W-1:0]  rnd_q, dbl_q;

  salsa_dround u_dround (.s_i(x_q), .s_o(dr));

  function automatic state_t build(logic [KEY_W-1:0] k, logic kl, logic [NONCE_W-1:0] n);
    state_t           s;
    logic [KEY_W-1:0] kk;
    kk    = kl ? k : {k[KEY_W/2-1:0], k[KEY_W/2-1:0]};
    s[0]  = K_C0;
    s[5]  = kl ? K_C1_32 : K_C1_16;
    s[10] = kl ? K_C2_32 : K_C2_16;
    s[15] = K_C3;
    for (int i = 0; i < 4; i++) begin
      s[1+i]  = kk[WORD_W*i +: WORD_W];
      s[11+i] = kk[KEY_W/2 + WORD_W*i +: WORD_W];
    end
    s[6] = n[WORD_W-1:0];
    s[7] = n[NONCE_W-1:WORD_W];
    s[8] = '0;
    s[9] = '0;
    return s;
  endfunction

  function automatic state_t with_ctr(state_t s, logic [CNT_W-1:0] c);
    s[8] = c[WORD_W-1:0];
    s[9] = c[CNT_W-1:WORD_W];
    return s;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      x_q    <= '0;
      orig_q <= '0;
      blk_q  <= '0;
      ctr_q  <= '0;
      rnd_q  <= '0;
      dbl_q  <= '0;
    end else if (start_i) begin
      st_q   <= S_RUN;
      x_q    <= build(key_i, klen_i, nonce_i);
      orig_q <= build(key_i, klen_i, nonce_i);
      ctr_q  <= '0;
      rnd_q  <= '0;
      dbl_q  <= dbl_rounds(rsel_i);
    end else begin
      case (st_q)
        S_RUN: begin
          x_q   <= dr;
          rnd_q <= rnd_q + 1'b1;
          if (rnd_q == dbl_q - 1'b1) st_q <= S_FF;
        end
        S_FF: begin
          for (int i = 0; i < N_WORDS; i++) blk_q[i] <= x_q[i] + orig_q[i];
          st_q <= S_FULL;
        end
        S_FULL: begin
          if (take_i) begin
            ctr_q  <= ctr_q + 64'd1;
            x_q    <= with_ctr(orig_q, ctr_q + 64'd1);
            orig_q <= with_ctr(orig_q, ctr_q + 64'd1);
            rnd_q  <= '0;
            st_q   <= S_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  assign full_o = (st_q == S_FULL);
  assign blk_o  = blk_q;
endmodule

// File: rtl/salsa_kbuf.sv
module salsa_kbuf import salsa_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              full_i,
  input  state_t            blk_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              ready_o,
  output logic              dvalid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [BLK_W-1:0] buf_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q;
  logic             accept, last;

  assign accept = valid_i && vld_q && !flush_i;
  assign last   = accept && (idx_q == IDX_W'(OUT_WORDS-1));
  // refill when empty or in the same cycle the last word leaves
  assign take_o = full_i && !flush_i && (!vld_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q    <= '0;
      idx_q    <= '0;
      vld_q    <= 1'b0;
      dvalid_o <= 1'b0;
      data_o   <= '0;
    end else begin
      dvalid_o <= accept;
      if (accept) data_o <= data_i ^ buf_q[idx_q*DATA_W +: DATA_W];
      if (flush_i) begin
        idx_q <= '0;
        vld_q <= 1'b0;
      end else if (take_o) begin
        buf_q <= blk_i;
        idx_q <= '0;
        vld_q <= 1'b1;
      end else if (accept) begin
        idx_q <= idx_q + 1'b1;
        if (last) vld_q <= 1'b0;
      end
    end
  end

  assign ready_o = vld_q;
endmodule

// File: rtl/salsa_stream.sv
module salsa_stream import salsa_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          rounds_i,
  input  logic                key_len_i,
  input  logic                key_we_i,
  input  logic [SEL_W-1:0]    key_sel_i,
  input  logic [CHUNK_W-1:0]  key_chunk_i,
  input  logic                nonce_we_i,
  input  logic [NONCE_W-1:0]  nonce_i,
  input  logic                init_i,
  input  logic                valid_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                ready_o,
  output logic                dvalid_o,
  output logic [DATA_W-1:0]   data_o
);
  logic [KEY_W-1:0]   key_q;
  logic [NONCE_W-1:0] nonce_q;
  logic               full, take;
  state_t             blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      nonce_q <= '0;
    end else begin
      if (key_we_i)   key_q[key_sel_i*CHUNK_W +: CHUNK_W] <= key_chunk_i;
      if (nonce_we_i) nonce_q <= nonce_i;
    end
  end

  salsa_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (init_i),
    .take_i  (take),
    .klen_i  (key_len_i),
    .rsel_i  (rounds_i),
    .key_i   (key_q),
    .nonce_i (nonce_q),
    .full_o  (full),
    .blk_o   (blk)
  );

  salsa_kbuf u_kbuf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (init_i),
    .full_i   (full),
    .blk_i    (blk),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .take_o   (take),
    .ready_o  (ready_o),
    .dvalid_o (dvalid_o),
    .data_o   (data_o)
  );
endmodule

// File: rtl/salsa_stream_chk.sv
module salsa_stream_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_i,
  input logic        valid_i,
  input logic        ready_o,
  input logic        dvalid_o,
  input logic [63:0] data_o
);
  p_busy_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && valid_i) |=> !dvalid_o);

  p_result_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o |-> $past(valid_i && ready_o && !init_i));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_o && !init_i) |=> $stable(data_o));

  p_init_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!ready_o && !dvalid_o));

  p_ready_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(init_i || valid_i));

  always_comb begin
    if (!rst_ni) p_reset_r1: assert (!dvalid_o || $isunknown(dvalid_o));
  end
endmodule

bind salsa_stream salsa_stream_chk u_chk (.*);

// File: tb/salsa_stream_tb.sv
`timescale 1ns/1ps
module salsa_stream_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  rounds_i = '0;
  logic        key_len_i = 1'b0;
  logic        key_we_i = 1'b0;
  logic [1:0]  key_sel_i = '0;
  logic [63:0] key_chunk_i = '0;
  logic        nonce_we_i = 1'b0;
  logic [63:0] nonce_i = '0;
  logic        init_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] data_i = '0;
  logic        ready_o, dvalid_o;
  logic [63:0] data_o;

  always #5 clk_i = ~clk_i;

  salsa_stream u_dut (.*);

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [255:0] key_r;
  logic [63:0]  nonce_r;
  bit           klen_r;
  int           nrnd_r;
  int           w_idx;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(logic [31:0] v, int s);
    return (v << s) | (v >> (32 - s));
  endfunction

  function automatic logic [511:0] ref_block(logic [63:0] ctr);
    logic [31:0]  x [16];
    logic [31:0]  z [16];
    int           q [8][4];
    logic [511:0] r;
    q = '{'{0,4,8,12}, '{5,9,13,1}, '{10,14,2,6}, '{15,3,7,11},
          '{0,1,2,3},  '{5,6,7,4},  '{10,11,8,9}, '{15,12,13,14}};
    x[0]  = 32'h61707865;
    x[5]  = klen_r ? 32'h3320646e : 32'h3120646e;
    x[10] = klen_r ? 32'h79622d32 : 32'h79622d36;
    x[15] = 32'h6b206574;
    for (int i = 0; i < 4; i++) begin
      x[1+i]  = key_r[32*i +: 32];
      x[11+i] = klen_r ? key_r[128 + 32*i +: 32] : key_r[32*i +: 32];
    end
    x[6] = nonce_r[31:0];
    x[7] = nonce_r[63:32];
    x[8] = ctr[31:0];
    x[9] = ctr[63:32];
    z = x;
    for (int d = 0; d < nrnd_r / 2; d++) begin
      for (int k = 0; k < 8; k++) begin
        int a = q[k][0];
        int b = q[k][1];
        int c = q[k][2];
        int e = q[k][3];
        z[b] = z[b] ^ rl(z[a] + z[e], 7);
        z[c] = z[c] ^ rl(z[b] + z[a], 9);
        z[e] = z[e] ^ rl(z[c] + z[b], 13);
        z[a] = z[a] ^ rl(z[e] + z[c], 18);
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = z[i] + x[i];
    return r;
  endfunction

  function automatic logic [63:0] exp_word(int w);
    logic [511:0] b;
    b = ref_block(64'(w / 8));
    return b[64*(w % 8) +: 64];
  endfunction

  // R2 R3: load config, key chunks and nonce
  task automatic setup(int rsel, bit kl, int seed);
    for (int c = 0; c < 4; c++) begin
      logic [63:0] ch;
      for (int b = 0; b < 8; b++) ch[8*b +: 8] = 8'((8*c + b) * 13 + seed * 29 + 1);
      @(negedge clk_i);
      key_we_i = 1'b1; key_sel_i = 2'(c); key_chunk_i = ch;
      key_r[64*c +: 64] = ch;
    end
    @(negedge clk_i);
    key_we_i = 1'b0;
    nonce_we_i = 1'b1;
    nonce_i = {32'(seed) * 32'h01000193, 32'hC0DE_0000 ^ 32'(seed)};
    nonce_r = nonce_i;
    rounds_i = 2'(rsel); key_len_i = kl; klen_r = kl;
    nrnd_r = (rsel == 1) ? 12 : (rsel == 2) ? 8 : 20;
    @(negedge clk_i);
    nonce_we_i = 1'b0;
  endtask

  // pulse init with a request in the same cycle; returns at the first negedge with ready
  task automatic start(output int lat);
    bit busy_ok = 1;
    @(negedge clk_i);
    init_i = 1'b1; valid_i = 1'b1; data_i = 64'h1111_2222_3333_4444;
    @(negedge clk_i);
    init_i = 1'b0;
    chk(ready_o === 1'b0 && dvalid_o === 1'b0, "R10 init clears", {62'd0, ready_o, dvalid_o}, 64'd0);
    lat = 0;
    while (ready_o !== 1'b1 && lat < 200) begin
      @(negedge clk_i);
      lat++;
      if (dvalid_o !== 1'b0) busy_ok = 0;
    end
    chk(busy_ok, "R8 busy request ignored", 64'(busy_ok), 64'd1);
    w_idx = 0;
  endtask

  task automatic stream(int nwords, bit sparse, output int stalls);
    int issued = 0;
    int cyc = 0;
    stalls = 0;
    forever begin
      bit pend = 0;
      bit stl = 0;
      logic [63:0] pexp = '0;
      if (issued < nwords && (!sparse || (cyc % 2) == 0)) begin
        valid_i = 1'b1;
        data_i = {32'(cyc) * 32'h9E3779B9, 32'(w_idx) ^ 32'hA5A5_0F0F};
        if (ready_o === 1'b1) begin
          pend = 1; pexp = data_i ^ exp_word(w_idx); w_idx++; issued++;
        end else begin
          stl = 1; stalls++;
        end
      end else begin
        valid_i = 1'b0;
      end
      cyc++;
      @(negedge clk_i);
      if (pend) chk(dvalid_o === 1'b1 && data_o === pexp,
                    sparse ? "R11 sparse word" : "R6 keystream word", data_o, pexp);
      else if (stl) chk(dvalid_o === 1'b0, "R8 stalled request", 64'(dvalid_o), 64'd0);
      if (issued >= nwords) break;
    end
    valid_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat, stalls, n, exp_st;
    int rs [7] = '{0, 1, 2, 0, 1, 2, 3};
    bit kls [7] = '{1, 1, 1, 0, 0, 0, 1};
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o === 1'b0 && dvalid_o === 1'b0 && data_o === 64'd0, "R1 reset",
        {data_o[61:0], ready_o, dvalid_o}, 64'd0);
    rst_ni = 1'b1;

    for (int t = 0; t < 7; t++) begin
      setup(rs[t], kls[t], t);
      start(lat);
      n = nrnd_r / 2;
      chk(lat == n + 2, "R5 init-to-ready latency", 64'(lat), 64'(n + 2));
      // R2 R3 R4 R6 R7: three blocks back to back
      stream(24, 0, stalls);
      exp_st = (n > 6) ? 2 * (n - 6) : 0;
      chk(stalls == exp_st, "R7 refill stall", 64'(stalls), 64'(exp_st));
      repeat (3) @(negedge clk_i);
      // R9 output held while idle
      chk(dvalid_o === 1'b0, "R9 idle strobe", 64'(dvalid_o), 64'd0);
    end

    // R11 sparse requests across a block boundary
    setup(1, 1, 9);
    start(lat);
    stream(11, 1, stalls);

    // R10 restart mid-stream: counter returns to zero
    stream(5, 0, stalls);
    start(lat);
    stream(9, 0, stalls);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule